// File: doc/BRIEF.md
# H-Bridge Command Decode and Fault Latch

This block is the digital control core of a motor driver built from two half-bridges. It turns two direction commands, an active-high park (tri-state) request and an active-high run enable into one drive state per half-bridge: pull high, pull low, or released. It also raises a sleep request and drives an open-drain style status flag. All four command pins pass through a synchronizer. Fault indications arrive already synchronized: a short-circuit pulse, two die-temperature levels (above the thermal limit, and below the limit minus hysteresis), and a supply-low level.

A short circuit or an overtemperature event latches both half-bridges off, whatever the direction commands say. The latch clears only on a falling edge of park or a rising edge of run enable, and the two faults accept these edges under different conditions. An overtemperature latch accepts the run-enable edge only once the die is no longer above the limit. It accepts the park edge only once the die is below the hysteresis point. A supply-low condition releases the bridge and holds the flag asserted only while it lasts. After reset, a power-on delay counter keeps the bridge released and the latches clear until it expires.

Top module: `bridge_cmd_core`

## Requirements
- R1: After reset, both half-bridges stay OFF (state code 2'b00) and faults are not latched until POD_CYCLES cycles have passed. A reset while a fault is latched clears the latch.
- R2: When park is low, run is high and no fault is present, each half-bridge follows its command: 1 gives HIGH (2'b01), 0 gives LOW (2'b10). Equal commands give both-low or both-high freewheeling.
- R3: Park high drives both half-bridges OFF and does not request sleep.
- R4: Run low drives both half-bridges OFF and asserts sleep_req.
- R5: A short_hit pulse latches both half-bridges OFF and asserts flag_pull_low (1 = flag pulled low). Command changes have no effect while the latch holds.
- R6: A falling edge of park clears a latched short circuit and restores the commanded states.
- R7: A rising edge of run clears a latched short circuit.
- R8: An overtemperature latch set by temp_over ignores a rising edge of run while temp_over is still high. It ignores a falling edge of park while temp_below_hys is low. A rising edge of run with temp_over low clears it.
- R9: A falling edge of park clears an overtemperature latch when temp_below_hys is high.
- R10: While supply_low is high, both half-bridges are OFF and flag_pull_low is 1. When supply_low falls, both recover with no input toggle.
- R11: For a half-bridge, hs_en and ls_en are never both 1. hs_en is 1 exactly when the state is HIGH, and ls_en exactly when it is LOW.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset (power cycle) |
| cmd_a | input | 1 | Direction command for half-bridge A |
| cmd_b | input | 1 | Direction command for half-bridge B |
| park_req | input | 1 | Active-high tri-state request |
| run_en | input | 1 | Active-high enable; low means sleep |
| short_hit | input | 1 | Short-circuit detect pulse |
| temp_over | input | 1 | Die above thermal limit |
| temp_below_hys | input | 1 | Die below limit minus hysteresis |
| supply_low | input | 1 | Undervoltage level |
| leg_a_state | output | 2 | Half-bridge A state: 00 OFF, 01 HIGH, 10 LOW |
| leg_b_state | output | 2 | Half-bridge B state |
| hs_en | output | 2 | High-side enables, bit 0 = A |
| ls_en | output | 2 | Low-side enables, bit 0 = A |
| sleep_req | output | 1 | Sleep request |
| flag_pull_low | output | 1 | 1 = status flag pulled low |

## Verification
The assertions check on every cycle that the high-side and low-side enables of a half-bridge never overlap. They also check that park, sleep, supply-low and the power-on window force both half-bridges OFF, that a short pulse sets the flag on the next cycle, and that an overtemperature latch cannot clear while the die is still hot. Only the bench scenarios can show which edges clear each latch and which are ignored, since that depends on ordered stimulus. The same holds for the direction decode, for command changes being ignored while latched, and for automatic recovery after undervoltage.

// File: rtl/bridge_pkg.sv
package bridge_pkg;

    localparam int NUM_LEGS = 2;

    typedef enum logic [1:0] {
        LEG_OFF  = 2'b00,
        LEG_HIGH = 2'b01,
        LEG_LOW  = 2'b10
    } leg_state_t;

    typedef struct packed {
        logic park;
        logic run;
        logic cmd_b;
        logic cmd_a;
    } pin_bundle_t;

    localparam int PIN_W = $bits(pin_bundle_t);

    // Pull defaults: commands high, parked, not running
    localparam pin_bundle_t PIN_IDLE = '{park: 1'b1, run: 1'b0, cmd_b: 1'b1, cmd_a: 1'b1};

    function automatic leg_state_t leg_decode(input logic allow, input logic cmd);
        if (!allow)
            return LEG_OFF;
        return cmd ? LEG_HIGH : LEG_LOW;
    endfunction

endpackage

// File: rtl/bridge_sync.sv
module bridge_sync #(
    parameter int              WIDTH     = 4,
    parameter int              STAGES    = 2,
    parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stage_q [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++)
                stage_q[i] <= RESET_VAL;
        end else begin
            stage_q[0] <= d;
            for (int i = 1; i < STAGES; i++)
                stage_q[i] <= stage_q[i-1];
        end
    end

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/bridge_pod_timer.sv
module bridge_pod_timer #(
    parameter int DELAY = 32
) (
    input  logic clk,
    input  logic rst,
    output logic done
);
    localparam int CW = $clog2(DELAY + 1);
    localparam logic [CW-1:0] LAST = CW'(DELAY);

    logic [CW-1:0] count_q;

    always_ff @(posedge clk) begin
        if (rst)
            count_q <= '0;
        else if (count_q != LAST)
            count_q <= count_q + 1'b1;
    end

    assign done = (count_q == LAST);
endmodule

// File: rtl/bridge_fault_latch.sv
module bridge_fault_latch (
    input  logic clk,
    input  logic rst,
    input  logic arm,
    input  logic short_hit,
    input  logic temp_over,
    input  logic temp_below_hys,
    input  logic park_fall,
    input  logic run_rise,
    output logic sc_q,
    output logic ot_q
);
    logic sc_clear, ot_clear;

    assign sc_clear = park_fall | run_rise;
    assign ot_clear = (run_rise & ~temp_over) | (park_fall & temp_below_hys);

    always_ff @(posedge clk) begin
        if (rst || !arm) begin
            sc_q <= 1'b0;
            ot_q <= 1'b0;
        end else begin
            // a new detection wins over a clearing edge in the same cycle
            if (short_hit)
                sc_q <= 1'b1;
            else if (sc_clear)
                sc_q <= 1'b0;
            if (temp_over)
                ot_q <= 1'b1;
            else if (ot_clear)
                ot_q <= 1'b0;
        end
    end
endmodule

// File: rtl/bridge_leg_decode.sv
module bridge_leg_decode
    import bridge_pkg::*;
#(
    parameter int LEGS = NUM_LEGS
) (
    input  logic            allow,
    input  logic [LEGS-1:0] cmd,
    output leg_state_t      state [LEGS],
    output logic [LEGS-1:0] hs_en,
    output logic [LEGS-1:0] ls_en
);
    for (genvar g = 0; g < LEGS; g++) begin : g_leg
        assign state[g] = leg_decode(allow, cmd[g]);
        assign hs_en[g] = (state[g] == LEG_HIGH);
        assign ls_en[g] = (state[g] == LEG_LOW);
    end
endmodule

// File: rtl/bridge_cmd_core.sv
module bridge_cmd_core
    import bridge_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int POD_CYCLES  = 32
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       cmd_a,
    input  logic       cmd_b,
    input  logic       park_req,
    input  logic       run_en,
    input  logic       short_hit,
    input  logic       temp_over,
    input  logic       temp_below_hys,
    input  logic       supply_low,
    output logic [1:0] leg_a_state,
    output logic [1:0] leg_b_state,
    output logic [1:0] hs_en,
    output logic [1:0] ls_en,
    output logic       sleep_req,
    output logic       flag_pull_low
);
    pin_bundle_t pins_raw, pins_s;
    logic        park_s, run_s, park_prev, run_prev;
    logic        park_fall, run_rise;
    logic        pod_done, sc_q, ot_q, allow;
    leg_state_t  leg_st [NUM_LEGS];

    assign pins_raw = '{park: park_req, run: run_en, cmd_b: cmd_b, cmd_a: cmd_a};

    bridge_sync #(
        .WIDTH    (PIN_W),
        .STAGES   (SYNC_STAGES),
        .RESET_VAL(PIN_IDLE)
    ) sync_i (
        .clk(clk),
        .rst(rst),
        .d  (pins_raw),
        .q  (pins_s)
    );

    assign park_s = pins_s.park;
    assign run_s  = pins_s.run;

    always_ff @(posedge clk) begin
        if (rst) begin
            park_prev <= PIN_IDLE.park;
            run_prev  <= PIN_IDLE.run;
        end else begin
            park_prev <= park_s;
            run_prev  <= run_s;
        end
    end

    assign park_fall = park_prev & ~park_s;
    assign run_rise  = ~run_prev & run_s;

    bridge_pod_timer #(.DELAY(POD_CYCLES)) pod_i (
        .clk (clk),
        .rst (rst),
        .done(pod_done)
    );

    bridge_fault_latch latch_i (
        .clk           (clk),
        .rst           (rst),
        .arm           (pod_done),
        .short_hit     (short_hit),
        .temp_over     (temp_over),
        .temp_below_hys(temp_below_hys),
        .park_fall     (park_fall),
        .run_rise      (run_rise),
        .sc_q          (sc_q),
        .ot_q          (ot_q)
    );

    assign allow = pod_done & ~park_s & run_s & ~sc_q & ~ot_q & ~supply_low;

    bridge_leg_decode #(.LEGS(NUM_LEGS)) dec_i (
        .allow(allow),
        .cmd  ({pins_s.cmd_b, pins_s.cmd_a}),
        .state(leg_st),
        .hs_en(hs_en),
        .ls_en(ls_en)
    );

    assign leg_a_state   = leg_st[0];
    assign leg_b_state   = leg_st[1];
    assign sleep_req     = ~run_s;
    assign flag_pull_low = sc_q | ot_q | supply_low;
endmodule

// File: rtl/bridge_cmd_core_chk.sv
module bridge_cmd_core_chk (
    input logic       clk,
    input logic       rst,
    input logic       pod_done,
    input logic       park_s,
    input logic       ot_q,
    input logic       temp_over,
    input logic       short_hit,
    input logic       supply_low,
    input logic       sleep_req,
    input logic       flag_pull_low,
    input logic [1:0] leg_a_state,
    input logic [1:0] leg_b_state,
    input logic [1:0] hs_en,
    input logic [1:0] ls_en
);
    logic both_off;
    assign both_off = (leg_a_state == 2'b00) && (leg_b_state == 2'b00);

    // R11
    side_overlap_chk: assert property (@(posedge clk) disable iff (rst)
        (hs_en & ls_en) == 2'b00);

    // R1
    pod_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !pod_done |-> both_off);

    // R3
    park_off_chk: assert property (@(posedge clk) disable iff (rst)
        park_s |-> both_off);

    // R4
    sleep_off_chk: assert property (@(posedge clk) disable iff (rst)
        sleep_req |-> both_off);

    // R5
    short_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (short_hit && pod_done) |=> (flag_pull_low && both_off));

    // R8
    ot_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (ot_q && temp_over) |=> ot_q);

    // R10
    uv_off_chk: assert property (@(posedge clk) disable iff (rst)
        supply_low |-> (flag_pull_low && both_off));
endmodule

bind bridge_cmd_core bridge_cmd_core_chk chk_i (
    .clk          (clk),
    .rst          (rst),
    .pod_done     (pod_done),
    .park_s       (park_s),
    .ot_q         (ot_q),
    .temp_over    (temp_over),
    .short_hit    (short_hit),
    .supply_low   (supply_low),
    .sleep_req    (sleep_req),
    .flag_pull_low(flag_pull_low),
    .leg_a_state  (leg_a_state),
    .leg_b_state  (leg_b_state),
    .hs_en        (hs_en),
    .ls_en        (ls_en)
);

// File: tb/bridge_cmd_core_tb.sv
module bridge_cmd_core_tb_top;
    localparam logic [1:0] S_OFF = 2'b00, S_HI = 2'b01, S_LO = 2'b10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cmd_a = 1'b1, cmd_b = 1'b1, park_req = 1'b1, run_en = 1'b0;
    logic short_hit = 1'b0, temp_over = 1'b0, temp_below_hys = 1'b0, supply_low = 1'b0;
    logic [1:0] leg_a_state, leg_b_state, hs_en, ls_en;
    logic sleep_req, flag_pull_low;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    bridge_cmd_core dut_i (
        .clk(clk), .rst(rst), .cmd_a(cmd_a), .cmd_b(cmd_b),
        .park_req(park_req), .run_en(run_en), .short_hit(short_hit),
        .temp_over(temp_over), .temp_below_hys(temp_below_hys),
        .supply_low(supply_low), .leg_a_state(leg_a_state),
        .leg_b_state(leg_b_state), .hs_en(hs_en), .ls_en(ls_en),
        .sleep_req(sleep_req), .flag_pull_low(flag_pull_low)
    );

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_out(input string req, input logic [1:0] ea, input logic [1:0] eb,
                              input logic eflag, input logic esleep);
        logic [1:0] ehs, els;
        ehs = {eb == S_HI, ea == S_HI};
        els = {eb == S_LO, ea == S_LO};
        n_checks++;
        if (leg_a_state !== ea || leg_b_state !== eb || hs_en !== ehs || ls_en !== els ||
            flag_pull_low !== eflag || sleep_req !== esleep) begin
            n_fails++;
            $display("FAIL %s: got a=%b b=%b hs=%b ls=%b flag=%b sleep=%b exp a=%b b=%b hs=%b ls=%b flag=%b sleep=%b",
                     req, leg_a_state, leg_b_state, hs_en, ls_en, flag_pull_low, sleep_req,
                     ea, eb, ehs, els, eflag, esleep);
        end
    endtask

    task automatic pulse_short();
        short_hit = 1'b1; step(1); short_hit = 1'b0; step(2);
    endtask

    task automatic t_power_on();
        rst = 1'b1; step(3); rst = 1'b0;
        park_req = 1'b0; run_en = 1'b1; cmd_a = 1'b1; cmd_b = 1'b0;
        step(6);
        expect_out("R1 held off in power-on window", S_OFF, S_OFF, 1'b0, 1'b0);
        step(40);
        expect_out("R1 released after delay", S_HI, S_LO, 1'b0, 1'b0);
    endtask

    task automatic t_direction();
        cmd_a = 1'b0; cmd_b = 1'b1; step(4);
        expect_out("R2 reverse", S_LO, S_HI, 1'b0, 1'b0);
        cmd_a = 1'b0; cmd_b = 1'b0; step(4);
        expect_out("R2 low freewheel", S_LO, S_LO, 1'b0, 1'b0);
        cmd_a = 1'b1; cmd_b = 1'b1; step(4);
        expect_out("R2 high freewheel", S_HI, S_HI, 1'b0, 1'b0);
        cmd_a = 1'b1; cmd_b = 1'b0; step(4);
        expect_out("R11 forward enables", S_HI, S_LO, 1'b0, 1'b0);
    endtask

    task automatic t_disables();
        park_req = 1'b1; step(4);
        expect_out("R3 park tri-states", S_OFF, S_OFF, 1'b0, 1'b0);
        park_req = 1'b0; step(4);
        expect_out("R3 park release", S_HI, S_LO, 1'b0, 1'b0);
        run_en = 1'b0; step(4);
        expect_out("R4 sleep tri-states", S_OFF, S_OFF, 1'b0, 1'b1);
        run_en = 1'b1; step(4);
        expect_out("R4 wake", S_HI, S_LO, 1'b0, 1'b0);
    endtask

    task automatic t_short_clears();
        pulse_short();
        expect_out("R5 short latched", S_OFF, S_OFF, 1'b1, 1'b0);
        cmd_a = 1'b0; cmd_b = 1'b1; step(5);
        expect_out("R5 commands ignored while latched", S_OFF, S_OFF, 1'b1, 1'b0);
        park_req = 1'b1; step(4); park_req = 1'b0; step(5);
        expect_out("R6 park fall clears short", S_LO, S_HI, 1'b0, 1'b0);
        pulse_short();
        expect_out("R5 short latched again", S_OFF, S_OFF, 1'b1, 1'b0);
        run_en = 1'b0; step(4); run_en = 1'b1; step(5);
        expect_out("R7 run rise clears short", S_LO, S_HI, 1'b0, 1'b0);
    endtask

    task automatic t_overtemp();
        temp_over = 1'b1; step(2);
        expect_out("R8 overtemp latched", S_OFF, S_OFF, 1'b1, 1'b0);
        run_en = 1'b0; step(4); run_en = 1'b1; step(5);
        expect_out("R8 run edge ignored while hot", S_OFF, S_OFF, 1'b1, 1'b0);
        temp_over = 1'b0; temp_below_hys = 1'b0; step(2);
        park_req = 1'b1; step(4); park_req = 1'b0; step(5);
        expect_out("R8 park edge ignored above hysteresis", S_OFF, S_OFF, 1'b1, 1'b0);
        run_en = 1'b0; step(4); run_en = 1'b1; step(5);
        expect_out("R8 run edge clears when below limit", S_LO, S_HI, 1'b0, 1'b0);
        temp_over = 1'b1; step(2); temp_over = 1'b0; temp_below_hys = 1'b1; step(2);
        expect_out("R9 overtemp latched again", S_OFF, S_OFF, 1'b1, 1'b0);
        park_req = 1'b1; step(4); park_req = 1'b0; step(5);
        expect_out("R9 park fall clears below hysteresis", S_LO, S_HI, 1'b0, 1'b0);
        temp_below_hys = 1'b0;
    endtask

    task automatic t_undervoltage();
        supply_low = 1'b1; step(2);
        expect_out("R10 undervoltage off", S_OFF, S_OFF, 1'b1, 1'b0);
        supply_low = 1'b0; step(2);
        expect_out("R10 auto recovery", S_LO, S_HI, 1'b0, 1'b0);
    endtask

    task automatic t_power_cycle();
        pulse_short();
        expect_out("R1 latched before power cycle", S_OFF, S_OFF, 1'b1, 1'b0);
        rst = 1'b1; step(2); rst = 1'b0; step(45);
        expect_out("R1 power cycle clears latch", S_LO, S_HI, 1'b0, 1'b0);
    endtask

    initial begin
        step(1);
        t_power_on();
        t_direction();
        t_disables();
        t_short_clears();
        t_overtemp();
        t_undervoltage();
        t_power_cycle();
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: run did not complete, got timeout exp completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end
endmodule